// File: doc/BRIEF.md
# Lightweight Feistel Cipher Core

This block encrypts one 32-bit word under a 64-bit key. The word is cut into two 16-bit halves and sent through a 32-round Feistel network. Before the rounds start, the four 16-bit key words are expanded into 32 round-key words. A 2-bit lane selector rotates the order in which the round keys inside each aligned group of four are used. One key can therefore drive four different ciphers.

An operation begins when `start_i` is sampled high while the block is idle. On that edge the block captures the data word, the key and the lane. It then spends one cycle per expanded key word (28 cycles with the defaults), followed by one cycle per round (32 cycles). When the last round completes, `done_o` pulses for one cycle and `data_o` takes the ciphertext. `data_o` keeps that value until the next operation completes. Every operation captures its own key, so the key may change freely between operations.

Top module: `lfc_core`

## Requirements
- R1: While `rst_ni` is low and after reset, `busy_o` is 0, `done_o` is 0 and `data_o` is 0.
- R2: `start_i` sampled high while `busy_o` is low begins an operation. `busy_o` is high from the next cycle for exactly 2*ROUNDS-4 cycles (60 with the defaults): ROUNDS-4 expansion cycles, then ROUNDS round cycles.
- R3: `done_o` is high for exactly one cycle, in the first cycle after `busy_o` falls. `done_o` and `busy_o` are never high together.
- R4: The input left half is `data_i[15:0]` and the right half is `data_i[31:16]`. `data_o` is {final right half, final left half}, with the right half in bits [31:16].
- R5: Key word 0 is `key_i[63:48]`, word 1 is `key_i[47:32]`, word 2 is `key_i[31:16]` and word 3 is `key_i[15:0]`. Every accepted start captures a new key.
- R6: For i = 0..ROUNDS-5, k[i+4] = 0xFFFC ^ c_i ^ k[i] ^ t ^ ror16(t,1), where t = ror16(k[i+3],3) ^ k[i+1]. c_i is bit (63-i) of 0xFA2561CDF44AC398, placed at bit 0.
- R7: Round r computes new_left = right ^ f(left) ^ rk_r and new_right = left, where f(x) = (rol16(x,1) & rol16(x,8)) ^ rol16(x,2).
- R8: The round key for round 4g+j (j = 0..3) is k[4g + ((j + lane) mod 4)]. The lane is the value of `lane_i` captured at start.
- R9: While `busy_o` is high, `start_i`, `data_i`, `key_i` and `lane_i` have no effect on the result of the operation in progress.
- R10: `data_o` changes only in the cycle in which `done_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation when idle |
| data_i | input | 32 | Plaintext word |
| key_i | input | 64 | Cipher key |
| lane_i | input | 2 | Round-key rotation select |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| data_o | output | 32 | Ciphertext, held until the next completion |

## Verification
The assertions rely on one assumption about the inputs: `start_i` is a synchronous level that counts only when the block is idle. They therefore expect the captured lane to stay stable and `data_o` to change only with `done_o`, whatever `start_i` does during an operation. The stimulus changes all inputs only on the falling clock edge. It also deliberately holds `start_i` high during operations, with a different key, data word and lane, so that the ignored-start path is exercised. It issues starts in the very cycle `done_o` is high, which checks that the block re-arms with no idle gap.

// File: rtl/lfc_pkg.sv
package lfc_pkg;
  localparam int HW    = 16;
  localparam int NK    = 4;
  localparam int KEY_W = HW * NK;
  localparam logic [63:0]   ZSEQ  = 64'hFA2561CDF44AC398;
  localparam logic [HW-1:0] EXP_C = 16'hFFFC;

  typedef enum logic [1:0] {ST_IDLE, ST_EXP, ST_RND} state_e;

  function automatic logic [HW-1:0] rotl(input logic [HW-1:0] x, input int unsigned n);
    return (x << n) | (x >> (HW - n));
  endfunction

  function automatic logic [HW-1:0] rotr(input logic [HW-1:0] x, input int unsigned n);
    return (x >> n) | (x << (HW - n));
  endfunction

  function automatic logic [HW-1:0] mix(input logic [HW-1:0] x);
    return (rotl(x, 1) & rotl(x, 8)) ^ rotl(x, 2);
  endfunction
endpackage

// File: rtl/lfc_ctrl.sv
module lfc_ctrl import lfc_pkg::*; #(
  parameter int ROUNDS = 32,
  localparam int IW    = $clog2(ROUNDS),
  localparam int NEXP  = ROUNDS - NK
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic          busy_o,
  output logic          load_o,
  output logic          exp_o,
  output logic          rnd_o,
  output logic          last_o,
  output logic          done_o,
  output logic [IW-1:0] idx_o
);
  state_e        st;
  logic [IW-1:0] cnt;

  assign busy_o = (st != ST_IDLE);
  assign load_o = (st == ST_IDLE) && start_i;
  assign exp_o  = (st == ST_EXP);
  assign rnd_o  = (st == ST_RND);
  assign last_o = rnd_o && (cnt == IW'(ROUNDS - 1));
  assign idx_o  = cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= last_o;
      unique case (st)
        ST_IDLE: if (start_i) begin
          st  <= ST_EXP;
          cnt <= '0;
        end
        ST_EXP: if (cnt == IW'(NEXP - 1)) begin
          st  <= ST_RND;
          cnt <= '0;
        end else cnt <= cnt + 1'b1;
        ST_RND: if (last_o) begin
          st  <= ST_IDLE;
          cnt <= '0;
        end else cnt <= cnt + 1'b1;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assert_exp_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exp_o |-> cnt <= IW'(NEXP - 1));
  assert_rnd_entry_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rnd_o) |-> $past(exp_o));
  assert_done_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
endmodule

// File: rtl/lfc_key_sched.sv
module lfc_key_sched import lfc_pkg::*; #(
  parameter int ROUNDS = 32,
  localparam int IW    = $clog2(ROUNDS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [KEY_W-1:0] key_i,
  input  logic             step_i,
  input  logic [IW-1:0]    step_idx_i,
  input  logic [IW-1:0]    rd_idx_i,
  output logic [HW-1:0]    rk_o
);
  logic [HW-1:0] rf [ROUNDS];
  logic [HW-1:0] k0, k1, k3, t, nxt;
  logic [5:0]    zpos;
  logic          zbit;

  assign k0   = rf[step_idx_i];
  assign k1   = rf[step_idx_i + IW'(1)];
  assign k3   = rf[step_idx_i + IW'(3)];
  assign zpos = 6'd63 - 6'(step_idx_i);
  assign zbit = ZSEQ[zpos];
  assign t    = rotr(k3, 3) ^ k1;
  // constant bit enters at bit 0
  assign nxt  = EXP_C ^ {{(HW-1){1'b0}}, zbit} ^ k0 ^ t ^ rotr(t, 1);
  assign rk_o = rf[rd_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ROUNDS; i++) rf[i] <= '0;
    end else if (load_i) begin
      for (int j = 0; j < NK; j++) rf[j] <= key_i[KEY_W-1-HW*j -: HW];
    end else if (step_i) begin
      rf[step_idx_i + IW'(NK)] <= nxt;
    end
  end

  assert_key_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (rf[0] == $past(key_i[KEY_W-1 -: HW])) && (rf[NK-1] == $past(key_i[HW-1:0])));
endmodule

// File: rtl/lfc_round.sv
module lfc_round import lfc_pkg::*; (
  input  logic [HW-1:0] left_i,
  input  logic [HW-1:0] right_i,
  input  logic [HW-1:0] rk_i,
  output logic [HW-1:0] left_o,
  output logic [HW-1:0] right_o
);
  assign left_o  = right_i ^ mix(left_i) ^ rk_i;
  assign right_o = left_i;
endmodule

// File: rtl/lfc_core.sv
module lfc_core import lfc_pkg::*; #(
  parameter int ROUNDS = 32,
  localparam int IW    = $clog2(ROUNDS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [2*HW-1:0]  data_i,
  input  logic [KEY_W-1:0] key_i,
  input  logic [1:0]       lane_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [2*HW-1:0]  data_o
);
  logic          load, exp_step, rnd_step, last;
  logic [IW-1:0] idx, rd_idx;
  logic [1:0]    lane_q, sub;
  logic [HW-1:0] left_q, right_q, rk, nl, nr;

  // rotate within the aligned group of four
  assign sub    = idx[1:0] + lane_q;
  assign rd_idx = {idx[IW-1:2], sub};

  lfc_ctrl #(.ROUNDS(ROUNDS)) ctrl_i (
    .clk_i, .rst_ni, .start_i,
    .busy_o, .load_o(load), .exp_o(exp_step), .rnd_o(rnd_step),
    .last_o(last), .done_o, .idx_o(idx)
  );

  lfc_key_sched #(.ROUNDS(ROUNDS)) ks_i (
    .clk_i, .rst_ni, .load_i(load), .key_i,
    .step_i(exp_step), .step_idx_i(idx), .rd_idx_i(rd_idx), .rk_o(rk)
  );

  lfc_round rnd_i (
    .left_i(left_q), .right_i(right_q), .rk_i(rk),
    .left_o(nl), .right_o(nr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lane_q  <= '0;
      left_q  <= '0;
      right_q <= '0;
      data_o  <= '0;
    end else begin
      if (load) begin
        lane_q  <= lane_i;
        left_q  <= data_i[HW-1:0];
        right_q <= data_i[2*HW-1:HW];
      end else if (rnd_step) begin
        left_q  <= nl;
        right_q <= nr;
      end
      if (last) data_o <= {nr, nl};
    end
  end

  assert_lane_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(lane_q));
  assert_out_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(data_o));
endmodule

// File: tb/lfc_core_tb_top.sv
module lfc_core_tb_top;
  localparam int LAT = 60;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start = 1'b0;
  logic [31:0] din = '0;
  logic [63:0] key = '0;
  logic [1:0]  lane = '0;
  logic        busy, done;
  logic [31:0] dout;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  lfc_core dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .data_i(din),
    .key_i(key), .lane_i(lane), .busy_o(busy), .done_o(done), .data_o(dout)
  );

  function automatic logic [15:0] rl(input logic [15:0] x, input int n);
    logic [31:0] w;
    w = {x, x} << n;
    return w[31:16];
  endfunction

  function automatic logic [15:0] rr(input logic [15:0] x, input int n);
    return rl(x, 16 - n);
  endfunction

  function automatic logic [31:0] ref_enc(input logic [31:0] x, input logic [63:0] k_in,
                                          input logic [1:0] ln);
    logic [15:0] k [32];
    logic [15:0] t, l, r, nl;
    logic [63:0] zs;
    int ix;
    zs = 64'hFA2561CDF44AC398;
    for (int i = 0; i < 4; i++) k[i] = k_in[63-16*i -: 16];
    for (int i = 0; i < 28; i++) begin
      t = rr(k[i+3], 3) ^ k[i+1];
      k[i+4] = 16'hFFFC ^ {15'd0, zs[63-i]} ^ k[i] ^ t ^ rr(t, 1);
    end
    l = x[15:0];
    r = x[31:16];
    for (int i = 0; i < 32; i++) begin
      ix = (i / 4) * 4 + ((i % 4) + int'(ln)) % 4;
      nl = r ^ ((rl(l, 1) & rl(l, 8)) ^ rl(l, 2)) ^ k[ix];
      r = l;
      l = nl;
    end
    return {r, l};
  endfunction

  // cycle model
  int          m_cnt = 0;
  logic        m_done = 1'b0;
  logic [31:0] m_data = '0, m_res = '0;

  always @(posedge clk) begin
    if (!rst_ni) begin
      m_cnt <= 0; m_done <= 1'b0; m_data <= '0;
    end else begin
      m_done <= (m_cnt == 1);
      if (m_cnt == 1) m_data <= m_res;
      if (m_cnt > 0) m_cnt <= m_cnt - 1;
      else if (start) begin
        m_cnt <= LAT;
        m_res <= ref_enc(din, key, lane);
      end
    end
  end

  task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_ni) begin
      check(busy == (m_cnt > 0), "R2 busy", 32'(busy), 32'(m_cnt > 0));
      check(done == m_done, "R3 done", 32'(done), 32'(m_done));
      check(dout == m_data, "R4 R6 R7 R8 R10 data_o", dout, m_data);
    end
  end

  task automatic wait_done();
    while (!done) @(negedge clk);
  endtask

  task automatic go(input logic [31:0] d, input logic [63:0] k, input logic [1:0] l, input string tag);
    start = 1'b1; din = d; key = k; lane = l;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    check(dout == ref_enc(d, k, l), tag, dout, ref_enc(d, k, l));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int bcnt;
    logic [31:0] held;
    repeat (3) @(negedge clk);
    check(!busy && !done && dout == 0, "R1 reset state", {busy, done, dout[29:0]}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    check(!busy && !done && dout == 0, "R1 after reset", {busy, done, dout[29:0]}, 32'd0);

    // R2 latency count
    start = 1'b1; din = 32'h0123_4567; key = 64'h1918_1110_0908_0100; lane = 2'd0;
    @(negedge clk);
    start = 1'b0;
    bcnt = 0;
    while (busy) begin bcnt++; @(negedge clk); end
    check(bcnt == LAT, "R2 busy length", bcnt, LAT);
    check(done == 1'b1, "R3 done after busy falls", 32'(done), 1);
    check(dout == ref_enc(32'h0123_4567, 64'h1918_1110_0908_0100, 2'd0), "R4 R7 result", dout,
          ref_enc(32'h0123_4567, 64'h1918_1110_0908_0100, 2'd0));
    @(negedge clk);

    // R8 every lane, same key and data
    for (int l = 0; l < 4; l++) begin
      go(32'hDEAD_BEEF, 64'hA5A5_0F0F_3C3C_9696, 2'(l), "R8 lane result");
      @(negedge clk);
    end
    // R6 constants only
    go(32'h0, 64'h0, 2'd0, "R6 zero key");
    // back-to-back start in done cycle, R5 new key
    go(32'hFFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 2'd3, "R5 R7 ones back-to-back");
    go(32'h8000_0001, 64'h0001_0002_0004_0008, 2'd2, "R5 key change");
    @(negedge clk);

    // R9 start held high with other inputs while busy
    start = 1'b1; din = 32'h1357_9BDF; key = 64'hCAFE_F00D_1234_5678; lane = 2'd1;
    @(negedge clk);
    din = 32'h2468_ACE0; key = 64'h0; lane = 2'd2;
    repeat (20) @(negedge clk);
    start = 1'b0;
    wait_done();
    check(dout == ref_enc(32'h1357_9BDF, 64'hCAFE_F00D_1234_5678, 2'd1), "R9 ignored start",
          dout, ref_enc(32'h1357_9BDF, 64'hCAFE_F00D_1234_5678, 2'd1));

    // R10 hold while idle with changing inputs
    held = dout;
    @(negedge clk);
    for (int i = 0; i < 20; i++) begin
      din = 32'(i * 77); key = 64'(i * 12345); lane = 2'(i);
      @(negedge clk);
    end
    check(dout == held && !busy, "R10 output held", dout, held);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule